// File: doc/BRIEF.md
# Serial Flash Master with Byte-Count Transmit Ports

This block is a single-data-line serial master for a flash device, driven from a plain 32-bit register bus. Software queues transmit words into a FIFO through one of four write addresses. The address chosen tells the block how many bytes of the word are meaningful: one, two, three or all four. The shift engine sends only those bytes, starting at the lowest byte lane, most significant bit first. It collects the same number of bytes from the data-in line and places them in a receive FIFO that software drains by reading one address.

Clock polarity, clock phase and a power-of-two serial clock divider are held in a control word. That word also carries a manual chip-select mode in which software drives the select line directly. An enable register gates the shift engine. An interrupt status register shows live FIFO levels and two sticky overflow flags that are cleared by writing ones. A set/clear mask pair chooses which status bits raise the interrupt line. In the automatic mode the select line is held low from the first queued word until the transmit FIFO has drained, so a command, its address and its data can go out as one framed transaction.

Top module: `spi_flash_master`

## Requirements
- R1: After reset the control word reads 0x0000_0400, interrupt status (0x04) reads 0x04, and cs_n is 1, sclk is 0 and irq is 0.
- R2: A write to 0x80, 0x84 or 0x88 queues an entry of 1, 2 or 3 bytes taken from the low lanes of the written word. A write to 0x1C queues all 4 bytes. Bytes go out from lane 0 upward, each byte MSB first.
- R3: For an entry of N bytes, the receive word read at 0x20 holds the first received byte in lane 4-N and the last in lane 3. Lanes below 4-N read zero. Each read pops one word.
- R4: The serial clock period is 2 << D reference cycles, where D is control bits 5:3; each half period lasts 1 << D cycles.
- R5: Control bit 1 sets the idle level of sclk. With control bit 2 clear, data in is sampled on the leading edge; with it set, on the trailing edge. Data out changes on the opposite edge.
- R6: While enable bit 0 (address 0x14) is 1, queued entries are sent back to back. With control bit 14 clear, cs_n is low from the start of the first entry until the transmit FIFO is empty and the last entry has finished.
- R7: With control bit 14 set, cs_n equals control bit 10.
- R8: While the enable bit is 0, sclk makes no edges and queued entries stay in place. Clearing the enable bit during an entry abandons it, and that entry produces no receive word.
- R9: Live status bits are 2 (transmit FIFO not full), 3 (transmit FIFO full), 4 (receive FIFO not empty) and 5 (receive FIFO full).
- R10: A transmit-port write while the transmit FIFO is full is dropped and sets sticky status bit 0. Writing 1 to that bit clears it.
- R11: A received word that completes while the receive FIFO is full is dropped and sets sticky status bit 6. Writing 1 to that bit clears it.
- R12: Reading 0x20 while the receive FIFO is empty returns zero.
- R13: Writing ones to 0x08 sets mask bits and writing ones to 0x0C clears them. The mask reads back at 0x10, and irq is the OR of the status bits that are both set and masked in.
- R14: Each FIFO holds FIFO_DEPTH entries: the full flag sets at exactly FIFO_DEPTH queued entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at 0x20) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with FIFO_DEPTH = 4 instead of 63. This lets a handful of writes reach the transmit full flag, the dropped-write flag, a full receive FIFO and the dropped-receive flag. With the small depth every overflow path gets exercised in a few hundred cycles. The bench also sweeps all four clock polarity and phase combinations and divider values 0 to 2. A modelled flash returns a known byte stream, so both the transmit and the receive byte ordering can be checked for every entry length.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_ISR  = 8'h04;
  localparam logic [7:0] A_IER  = 8'h08;
  localparam logic [7:0] A_IDR  = 8'h0C;
  localparam logic [7:0] A_IMR  = 8'h10;
  localparam logic [7:0] A_ENR  = 8'h14;
  localparam logic [7:0] A_TX4  = 8'h1C;
  localparam logic [7:0] A_RXD  = 8'h20;
  localparam logic [7:0] A_TX1  = 8'h80;
  localparam logic [7:0] A_TX2  = 8'h84;
  localparam logic [7:0] A_TX3  = 8'h88;

  localparam logic [31:0] CTRL_MASK  = 32'h8000_C43F;
  localparam logic [31:0] CTRL_RESET = 32'h0000_0400;

  // number of valid bytes implied by a transmit address, 0 if not a transmit port
  function automatic logic [2:0] port_bytes(input logic [7:0] a);
    case (a)
      A_TX1:   return 3'd1;
      A_TX2:   return 3'd2;
      A_TX3:   return 3'd3;
      A_TX4:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // reorders lanes so that lane 0 sits in the top byte of the shift register
  function automatic logic [31:0] lane_order(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [5:0] bits_of(input logic [1:0] nb_m1);
    return {1'b0, nb_m1, 3'b000} + 6'd8;
  endfunction

  // reference cycles per half period of the serial clock
  function automatic logic [7:0] half_period(input logic [2:0] div);
    return 8'd1 << div;
  endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] pdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= pdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter import spim_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        cpol,
  input  logic        cpha,
  input  logic [2:0]  div,
  input  logic        ent_valid,
  input  logic [31:0] ent_data,
  input  logic [1:0]  ent_nbm1,
  output logic        ent_pop,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        busy,
  output logic        rx_push,
  output logic [31:0] rx_word
);
  logic [7:0]  hcnt;
  logic [31:0] sr, rxw;
  logic [7:0]  rxb;
  logic [5:0]  bcnt, nbits;
  logic        sclk_r, mosi_r;

  wire [31:0] ld_sr = lane_order(ent_data);
  wire        tick  = busy && (hcnt == half_period(div) - 8'd1);
  wire        lead  = (sclk_r == cpol);
  wire        samp  = tick && (lead ^ cpha);
  wire        trail = tick && !lead;
  wire [7:0]  rxb_nx = samp ? {rxb[6:0], miso} : rxb;
  wire        last  = trail && (bcnt == nbits - 6'd1);

  assign ent_pop = !busy && en && ent_valid;
  assign sclk    = busy ? sclk_r : cpol;
  assign mosi    = mosi_r;
  assign rx_push = last;
  assign rx_word = {rxb_nx, rxw[31:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sclk_r <= 1'b0;
      mosi_r <= 1'b0;
      hcnt   <= '0;
      sr     <= '0;
      rxw    <= '0;
      rxb    <= '0;
      bcnt   <= '0;
      nbits  <= '0;
    end else if (!en) begin
      busy   <= 1'b0;
      sclk_r <= cpol;
      hcnt   <= '0;
    end else if (ent_pop) begin
      busy   <= 1'b1;
      sr     <= ld_sr;
      nbits  <= bits_of(ent_nbm1);
      bcnt   <= '0;
      hcnt   <= '0;
      rxw    <= '0;
      rxb    <= '0;
      sclk_r <= cpol;
      if (!cpha) mosi_r <= ld_sr[31];
    end else if (busy) begin
      hcnt <= tick ? 8'd0 : hcnt + 8'd1;
      rxb  <= rxb_nx;
      if (tick) begin
        sclk_r <= ~sclk_r;
        if (lead && cpha) begin
          mosi_r <= sr[31];
          sr     <= sr << 1;
        end
        if (!lead) begin
          if (!cpha) begin
            mosi_r <= sr[30];
            sr     <= sr << 1;
          end
          bcnt <= bcnt + 6'd1;
          if (bcnt[2:0] == 3'd7) rxw <= {rxb_nx, rxw[31:8]};
          if (last) busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master import spim_pkg::*; #(
  parameter int FIFO_DEPTH = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  output logic        irq
);
  localparam int TXW = 34;

  logic [31:0] ctrl_q;
  logic        en_q;
  logic [6:0]  imr_q;
  logic        sts_txovf, sts_rxovf;

  // named events for the checker
  logic [2:0] tx_nb;
  logic       tx_wr_evt, rx_rd_evt;
  logic       tx_empty, tx_full, rx_empty, rx_full;
  logic       eng_busy, ent_pop, rx_push;
  logic [TXW-1:0] tx_head;
  logic [31:0] rx_head, rx_word;
  logic [6:0]  isr_view;

  assign tx_nb     = port_bytes(bus_addr);
  assign tx_wr_evt = bus_wr && (tx_nb != 3'd0);
  assign rx_rd_evt = bus_rd && (bus_addr == A_RXD);

  wire wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  wire wr_isr  = bus_wr && (bus_addr == A_ISR);
  wire wr_ier  = bus_wr && (bus_addr == A_IER);
  wire wr_idr  = bus_wr && (bus_addr == A_IDR);
  wire wr_enr  = bus_wr && (bus_addr == A_ENR);

  spim_fifo #(.W(TXW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_wr_evt), .pdata({2'(tx_nb - 3'd1), bus_wdata}),
    .pop(ent_pop), .head(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spim_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .pdata(rx_word),
    .pop(rx_rd_evt), .head(rx_head), .empty(rx_empty), .full(rx_full)
  );

  spim_shifter u_eng (
    .clk(clk), .rst_n(rst_n), .en(en_q),
    .cpol(ctrl_q[1]), .cpha(ctrl_q[2]), .div(ctrl_q[5:3]),
    .ent_valid(!tx_empty), .ent_data(tx_head[31:0]), .ent_nbm1(tx_head[33:32]),
    .ent_pop(ent_pop), .miso(miso), .sclk(sclk), .mosi(mosi),
    .busy(eng_busy), .rx_push(rx_push), .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_RESET;
      en_q      <= 1'b0;
      imr_q     <= '0;
      sts_txovf <= 1'b0;
      sts_rxovf <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
      if (wr_enr)  en_q   <= bus_wdata[0];
      if (wr_ier)      imr_q <= imr_q | bus_wdata[6:0];
      else if (wr_idr) imr_q <= imr_q & ~bus_wdata[6:0];
      if (tx_wr_evt && tx_full)     sts_txovf <= 1'b1;
      else if (wr_isr && bus_wdata[0]) sts_txovf <= 1'b0;
      if (rx_push && rx_full)       sts_rxovf <= 1'b1;
      else if (wr_isr && bus_wdata[6]) sts_rxovf <= 1'b0;
    end
  end

  assign isr_view = {sts_rxovf, rx_full, !rx_empty, tx_full, !tx_full, 1'b0, sts_txovf};
  assign irq      = |(isr_view & imr_q);

  wire cs_act = en_q && (eng_busy || !tx_empty);
  assign cs_n = ctrl_q[14] ? ctrl_q[10] : !cs_act;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = ctrl_q;
        A_ISR:   bus_rdata = {25'd0, isr_view};
        A_IMR:   bus_rdata = {25'd0, imr_q};
        A_ENR:   bus_rdata = {31'd0, en_q};
        A_RXD:   bus_rdata = rx_empty ? 32'd0 : rx_head;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_master_chk.sv
module spi_flash_master_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_wr,
  input logic tx_full,
  input logic tx_ovf,
  input logic rx_push,
  input logic rx_full,
  input logic rx_ovf,
  input logic manual,
  input logic busy,
  input logic en,
  input logic cs_n
);
  // R10
  tx_drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && tx_full |=> tx_ovf);

  // R11
  rx_drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full |=> rx_ovf);

  // R6
  auto_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !manual && busy && en |-> !cs_n);

  // R8
  gate_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  // R6
  entry_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rx_push) || !$past(en));
endmodule

bind spi_flash_master spi_flash_master_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_wr(tx_wr_evt), .tx_full(tx_full), .tx_ovf(sts_txovf),
  .rx_push(rx_push), .rx_full(rx_full), .rx_ovf(sts_rxovf),
  .manual(ctrl_q[14]), .busy(eng_busy), .en(en_q), .cs_n(cs_n)
);

// File: tb/spi_flash_master_tb.sv
module spi_flash_master_tb;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sclk, mosi, cs_n, irq;
  logic miso = 1'b0;

  always #5 clk = ~clk;

  spi_flash_master #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // ---------------- bus access ----------------
  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  // ---------------- flash model ----------------
  logic cpol_b = 0, cpha_b = 0, active = 0;
  int   s_idx = 0;
  logic [7:0] txlog [0:63];
  longint last_t = -1, min_iv = 1000000;
  int   edge_cnt = 0;

  function automatic logic [7:0] sbyte(input int k);
    return 8'(k * 29 + 90);
  endfunction

  function automatic logic sbit(input int s);
    logic [7:0] b;
    b = sbyte(s / 8);
    return b[7 - (s % 8)];
  endfunction

  always @(sclk) begin
    if (rst_n) edge_cnt++;
    if (active && rst_n) begin
      if (last_t >= 0 && ($time - last_t) < min_iv) min_iv = $time - last_t;
      last_t = $time;
      if ((sclk != cpol_b) != cpha_b) begin
        txlog[s_idx / 8] = {txlog[s_idx / 8][6:0], mosi};
        s_idx++;
        miso = sbit(s_idx);
      end
    end
  end

  // ---------------- expectation bookkeeping ----------------
  logic [31:0] exp_rx [0:15];
  logic [7:0]  exp_tx [0:63];
  int ne = 0, nb_total = 0;

  function automatic logic [7:0] tx_addr(input int n);
    case (n)
      1: return 8'h80;
      2: return 8'h84;
      3: return 8'h88;
      default: return 8'h1C;
    endcase
  endfunction

  function automatic logic [31:0] rx_expect(input int base, input int n);
    logic [31:0] w = '0;
    for (int j = 0; j < n; j++) w[8 * (4 - n + j) +: 8] = sbyte(base + j);
    return w;
  endfunction

  function automatic logic [31:0] ctrl_val(input logic p, input logic h, input logic [2:0] d);
    return 32'h0000_0401 | {29'd0, h, p, 1'b0} | {26'd0, d, 3'd0};
  endfunction

  task automatic push_entry(input int n, input logic [31:0] d);
    bwr(tx_addr(n), d);
    exp_rx[ne] = rx_expect(nb_total, n);
    for (int j = 0; j < n; j++) exp_tx[nb_total + j] = d[8 * j +: 8];
    nb_total += n;
    ne++;
  endtask

  task automatic start_batch(input logic p, input logic h, input logic [2:0] d);
    active = 0;
    bwr(8'h14, 32'd0);
    bwr(8'h00, ctrl_val(p, h, d));
    cpol_b = p; cpha_b = h;
    s_idx = 0; miso = sbit(0);
    last_t = -1; min_iv = 1000000;
    ne = 0; nb_total = 0;
    for (int i = 0; i < 64; i++) txlog[i] = 8'h00;
    active = 1;
  endtask

  task automatic end_checks(input logic [2:0] d);
    check("R2 bits shifted", 32'(s_idx), 32'(nb_total * 8));
    for (int b = 0; b < nb_total; b++)
      check("R2 transmit byte", {24'd0, txlog[b]}, {24'd0, exp_tx[b]});
    check("R4 half period", 32'(min_iv), 32'((1 << d) * 10));
    check("R5 idle level", {31'd0, sclk}, {31'd0, cpol_b});
  endtask

  logic [31:0] rd;

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    brd(8'h00, rd); check("R1 ctrl reset", rd, 32'h0000_0400);
    brd(8'h04, rd); check("R1 status reset", rd, 32'h04);
    check("R1 cs_n/sclk/irq", {29'd0, cs_n, sclk, irq}, {29'd0, 1'b1, 1'b0, 1'b0});

    // R7 manual select
    bwr(8'h00, 32'h0000_4001); @(negedge clk);
    check("R7 manual select low", {31'd0, cs_n}, 32'd0);
    bwr(8'h00, 32'h0000_4401); @(negedge clk);
    check("R7 manual select high", {31'd0, cs_n}, 32'd1);

    // R8 enable gating and abort
    start_batch(1'b0, 1'b0, 3'd2);
    active = 0;
    bwr(8'h1C, 32'hDEAD_BEEF);
    edge_cnt = 0;
    repeat (100) @(negedge clk);
    check("R8 no edges when disabled", 32'(edge_cnt), 32'd0);
    check("R8 select idle when disabled", {31'd0, cs_n}, 32'd1);
    brd(8'h04, rd); check("R8 entry held", rd, 32'h04);
    bwr(8'h14, 32'd1);
    repeat (20) @(negedge clk);
    check("R6 select during entry", {31'd0, cs_n}, 32'd0);
    bwr(8'h14, 32'd0);
    repeat (3) @(negedge clk);
    check("R8 abort select", {31'd0, cs_n}, 32'd1);
    check("R8 abort sclk idle", {31'd0, sclk}, 32'd0);
    brd(8'h04, rd); check("R8 abort no rx word", rd, 32'h04);

    // R2 R3 R4 R5 R6 random sweep
    for (int it = 0; it < 12; it++) begin
      logic [2:0] d;
      int k;
      d = 3'($urandom % 3);
      k = int'($urandom % DEPTH) + 1;
      start_batch(it[0], it[1], d);
      for (int e = 0; e < k; e++) push_entry(int'($urandom % 4) + 1, $urandom);
      bwr(8'h14, 32'd1);
      @(posedge cs_n);
      repeat (3) @(negedge clk);
      check("R6 back to back select", {31'd0, cs_n}, 32'd1);
      active = 0;
      end_checks(d);
      for (int e = 0; e < ne; e++) begin
        brd(8'h20, rd);
        check("R3 receive word", rd, exp_rx[e]);
      end
      brd(8'h04, rd); check("R9 drained status", rd, 32'h04);
    end

    // R14 R9 R10 R11 R12 overflow
    start_batch(1'b1, 1'b0, 3'd0);
    for (int e = 0; e < DEPTH - 1; e++) push_entry(4, $urandom);
    brd(8'h04, rd); check("R14 not full below depth", rd, 32'h04);
    push_entry(2, 32'h0000_A1B2);
    brd(8'h04, rd); check("R14 R9 full at depth", rd, 32'h08);
    bwr(8'h88, 32'h0012_3456);
    brd(8'h04, rd); check("R10 dropped write flag", rd, 32'h09);
    bwr(8'h04, 32'h01);
    brd(8'h04, rd); check("R10 clear by one", rd, 32'h08);
    bwr(8'h14, 32'd1);
    @(posedge cs_n);
    repeat (3) @(negedge clk);
    brd(8'h04, rd); check("R9 receive full", rd, 32'h34);
    push_entry(1, 32'h0000_0077);
    @(posedge cs_n);
    repeat (3) @(negedge clk);
    brd(8'h04, rd); check("R11 dropped receive flag", rd, 32'h74);
    bwr(8'h04, 32'h40);
    brd(8'h04, rd); check("R11 clear by one", rd, 32'h34);
    active = 0;
    end_checks(3'd0);
    for (int e = 0; e < DEPTH; e++) begin
      brd(8'h20, rd);
      check("R3 R11 kept words", rd, exp_rx[e]);
    end
    brd(8'h20, rd); check("R12 empty read zero", rd, 32'd0);
    brd(8'h04, rd); check("R12 status after empty read", rd, 32'h04);

    // R13 interrupt mask
    bwr(8'h08, 32'h14);
    brd(8'h10, rd); check("R13 mask set", rd, 32'h14);
    check("R13 irq from live bit", {31'd0, irq}, 32'd1);
    bwr(8'h0C, 32'h04);
    brd(8'h10, rd); check("R13 mask clear", rd, 32'h10);
    check("R13 irq masked", {31'd0, irq}, 32'd0);
    start_batch(1'b0, 1'b1, 3'd1);
    push_entry(3, 32'h00C0_FFEE);
    bwr(8'h14, 32'd1);
    @(posedge cs_n);
    repeat (3) @(negedge clk);
    check("R13 irq on receive", {31'd0, irq}, 32'd1);
    active = 0;
    end_checks(3'd1);
    brd(8'h20, rd); check("R3 three-byte word", rd, exp_rx[0]);
    check("R13 irq after drain", {31'd0, irq}, 32'd0);

    report();
    $finish;
  end
endmodule